// File: doc/BRIEF.md
# Transport Packet Capture Packer

The block sits behind a 10-bit video input bus and captures the bytes of a transport stream packet. Each byte is taken from the upper eight bits of the bus. Eight consecutive bytes are packed little-endian into one 64-bit word and presented to a receive FIFO. When a packet ends, any partly filled word is zero-padded and written. The next write is a 64-bit timestamp word. It holds the clock-reference snapshot that was latched when the packet's first byte arrived, plus two error flags collected over the packet.

Software programs the packet length as two 12-bit fields and chooses between two capture modes. In single-shot mode capture stops at a sticky frame-complete flag and resumes only when software clears that flag. In continuous mode packets keep arriving whatever the flag holds. Every completion raises a one-cycle interrupt pulse, which can be masked. When the FIFO signals full, offered bytes are dropped and the affected packet is marked as errored. Data and timestamp words are never reordered.

Top module: `tsPacker`

## Requirements
- R1: The captured byte is `vidIn[9:2]`. Within a data word, the k-th byte of the packet (counting k mod 8 from 0) occupies bits `8k+7:8k`. A data word appears on `wrData` with `wrEn` high in the cycle after the clock edge that accepts the byte completing it.
- R2: The packet length is `{sizeHi, sizeLo}` bytes, with `sizeHi` forming bits 23:12. When the length is not a multiple of eight, the last data word carries zeros in its unused upper bytes.
- R3: Every packet produces exactly one timestamp word. It is written in the cycle directly after the packet's last data word, and after all of that packet's data words.
- R4: Timestamp word layout: bit 63 is the packet error flag, bit 62 is the start error flag, and bits 61:42 are zero. Bits 41:0 copy `tsSnap[41:0]`, where `tsSnap[41:33]` is the 9-bit extension and `tsSnap[32:0]` is the 33-bit base.
- R5: `tsReq` is high, combinationally, exactly in the cycle in which a packet's first byte is accepted. The timestamp word of that packet carries the `tsSnap` value present in that cycle.
- R6: `frameDone` rises on the cycle after a packet's last byte is accepted. It stays high until a `flagClr` pulse clears it. A completion in the same cycle as `flagClr` wins.
- R7: `irqPulse` is high for exactly one cycle, together with the `frameDone` update, for each completed packet while `irqMask` is low. It stays low for packets completed while `irqMask` is high.
- R8: With `contMode` low, bytes offered while `frameDone` is high are ignored. They produce no writes and no `tsReq`.
- R9: With `contMode` high, capture of following packets continues while `frameDone` stays high.
- R10: A byte offered while `fifoFull` is high is dropped and not counted toward the packet length. It sets the packet error flag of the current packet.
- R11: `pktErrIn` and `startErrIn` are sampled with every accepted byte and ORed into bits 63 and 62 of the packet's timestamp word.
- R12: A byte offered in the cycle directly after a packet's last byte is accepted is dropped, because that cycle is the timestamp write slot. It sets the packet error flag of the next packet.
- R13: During and right after reset, `wrEn`, `frameDone` and `irqPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidIn | input | 10 | Video input bus; bits 9:2 carry the byte |
| vidValid | input | 1 | A byte is offered this cycle |
| sizeLo | input | 12 | Packet length bits 11:0 |
| sizeHi | input | 12 | Packet length bits 23:12 |
| contMode | input | 1 | 1 = continuous capture, 0 = single-shot |
| irqMask | input | 1 | Suppresses the completion pulse |
| flagClr | input | 1 | Clears the frame-complete flag |
| fifoFull | input | 1 | FIFO cannot take more bytes; offered bytes are dropped |
| pktErrIn | input | 1 | Packet error indication, sampled with each byte |
| startErrIn | input | 1 | Start error indication, sampled with each byte |
| tsSnap | input | 42 | Clock-reference snapshot: extension in 41:33, base in 32:0 |
| wrData | output | 64 | FIFO write data |
| wrEn | output | 1 | FIFO write enable |
| tsReq | output | 1 | Timestamp capture request on a packet's first byte |
| frameDone | output | 1 | Sticky frame-complete flag |
| irqPulse | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check the following on every cycle:
- no byte is accepted while the FIFO is full, while single-shot capture is halted, or in the timestamp slot;
- every last byte is followed by two consecutive writes;
- the frame flag sets and holds;
- the interrupt pulse lasts one cycle and coincides with the flag.

Only the bench's scenarios can show the following:
- the byte lanes, the zero padding and the 24-bit length assembled from both fields;
- that the timestamp word carries the snapshot taken at the first byte;
- that error flags land on the right packet after a drop.

These are shown by sweeping packet lengths and gap patterns and comparing every written word against a model.

// File: rtl/tsPackPkg.sv
package tsPackPkg;

  // Strobes from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic accept;    // a byte is taken this cycle
    logic wordDone;  // the byte taken closes a data word
    logic latchTs;   // first byte of a packet: latch the snapshot
    logic tsSlot;    // write the timestamp word this cycle
    logic perr;      // packet error flag for the timestamp word
    logic pstErr;    // start error flag for the timestamp word
  } ctlStrobes_t;

endpackage

// File: rtl/tsPackCtrl.sv
module tsPackCtrl
  import tsPackPkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int LANE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vidValid,
  input  logic               fifoFull,
  input  logic               contMode,
  input  logic               irqMask,
  input  logic               flagClr,
  input  logic               pktErrIn,
  input  logic               startErrIn,
  input  logic [FIELD_W-1:0] sizeLo,
  input  logic [FIELD_W-1:0] sizeHi,
  output ctlStrobes_t        ctl,
  output logic [LANE_W-1:0]  lane,
  output logic               tsReq,
  output logic               frameDone,
  output logic               irqPulse
);

  localparam int CNT_W = 2 * FIELD_W;

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] pktSize;
  logic             capEn;
  logic             offered;
  logic             blocked;
  logic             accept;
  logic             lastByte;
  logic             laneFull;
  logic             tsSlot;
  logic             perrAcc;
  logic             pstAcc;
  logic             perrSet;
  logic             pstSet;

  always_comb begin
    pktSize  = {sizeHi, sizeLo};
    cntNext  = byteCnt + 1'b1;
    capEn    = contMode | ~frameDone;
    offered  = vidValid & capEn;
    blocked  = fifoFull | tsSlot;
    accept   = offered & ~blocked;
    lastByte = accept & (cntNext == pktSize);
    laneFull = &byteCnt[LANE_W-1:0];
    perrSet  = (offered & blocked) | (accept & pktErrIn);
    pstSet   = accept & startErrIn;
  end

  // Byte counter within the current packet.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (lastByte) begin
      byteCnt <= '0;
    end else if (accept) begin
      byteCnt <= cntNext;
    end
  end

  // Timestamp slot follows the last byte; error flags restart there.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsSlot  <= 1'b0;
      perrAcc <= 1'b0;
      pstAcc  <= 1'b0;
    end else begin
      tsSlot <= lastByte;
      if (tsSlot) begin
        perrAcc <= perrSet;
        pstAcc  <= pstSet;
      end else begin
        perrAcc <= perrAcc | perrSet;
        pstAcc  <= pstAcc | pstSet;
      end
    end
  end

  // Sticky completion flag and interrupt pulse.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameDone <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (lastByte) begin
        frameDone <= 1'b1;
      end else if (flagClr) begin
        frameDone <= 1'b0;
      end
      irqPulse <= lastByte & ~irqMask;
    end
  end

  always_comb begin
    ctl.accept   = accept;
    ctl.wordDone = accept & (laneFull | lastByte);
    ctl.latchTs  = accept & (byteCnt == '0);
    ctl.tsSlot   = tsSlot;
    ctl.perr     = perrAcc;
    ctl.pstErr   = pstAcc;
    lane         = byteCnt[LANE_W-1:0];
    tsReq        = ctl.latchTs;
  end

endmodule

// File: rtl/tsPackData.sv
module tsPackData
  import tsPackPkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int BASE_W     = 33,
  parameter int EXT_W      = 9,
  parameter int LANE_W     = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [BYTE_W+1:0]            vidIn,
  input  logic [EXT_W+BASE_W-1:0]      tsSnap,
  input  ctlStrobes_t                  ctl,
  input  logic [LANE_W-1:0]            lane,
  output logic [WORD_BYTES*BYTE_W-1:0] wrData,
  output logic                         wrEn
);

  localparam int WORD_W = WORD_BYTES * BYTE_W;
  localparam int TS_W   = EXT_W + BASE_W;
  localparam int RSV_W  = WORD_W - 2 - TS_W;

  logic [BYTE_W-1:0] byteIn;
  logic [1:0]        unusedLow;
  logic [WORD_W-1:0] packReg;
  logic [WORD_W-1:0] merged;
  logic [TS_W-1:0]   tsHold;
  logic [WORD_W-1:0] tsWord;

  assign byteIn    = vidIn[BYTE_W+1:2];
  assign unusedLow = vidIn[1:0];

  // Lane steering: the incoming byte replaces its lane, the rest keep.
  for (genvar g = 0; g < WORD_BYTES; g++) begin : gLane
    assign merged[g*BYTE_W +: BYTE_W] =
      (ctl.accept && (lane == LANE_W'(g))) ? byteIn : packReg[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      packReg <= '0;
    end else if (ctl.wordDone) begin
      packReg <= '0;
    end else if (ctl.accept) begin
      packReg <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsHold <= '0;
    end else if (ctl.latchTs) begin
      tsHold <= tsSnap;
    end
  end

  assign tsWord = {ctl.perr, ctl.pstErr, {RSV_W{1'b0}}, tsHold};

  // FIFO write mux: a data word and the timestamp slot never coincide.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrData <= '0;
    end else if (ctl.wordDone) begin
      wrEn   <= 1'b1;
      wrData <= merged;
    end else if (ctl.tsSlot) begin
      wrEn   <= 1'b1;
      wrData <= tsWord;
    end else begin
      wrEn   <= 1'b0;
    end
  end

endmodule

// File: rtl/tsPacker.sv
module tsPacker
  import tsPackPkg::*;
#(
  parameter int FIELD_W    = 12,
  parameter int WORD_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int BASE_W     = 33,
  parameter int EXT_W      = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [BYTE_W+1:0]            vidIn,
  input  logic                         vidValid,
  input  logic [FIELD_W-1:0]           sizeLo,
  input  logic [FIELD_W-1:0]           sizeHi,
  input  logic                         contMode,
  input  logic                         irqMask,
  input  logic                         flagClr,
  input  logic                         fifoFull,
  input  logic                         pktErrIn,
  input  logic                         startErrIn,
  input  logic [EXT_W+BASE_W-1:0]      tsSnap,
  output logic [WORD_BYTES*BYTE_W-1:0] wrData,
  output logic                         wrEn,
  output logic                         tsReq,
  output logic                         frameDone,
  output logic                         irqPulse
);

  localparam int LANE_W = $clog2(WORD_BYTES);

  ctlStrobes_t       ctl;
  logic [LANE_W-1:0] lane;

  tsPackCtrl #(
    .FIELD_W (FIELD_W),
    .LANE_W  (LANE_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .vidValid   (vidValid),
    .fifoFull   (fifoFull),
    .contMode   (contMode),
    .irqMask    (irqMask),
    .flagClr    (flagClr),
    .pktErrIn   (pktErrIn),
    .startErrIn (startErrIn),
    .sizeLo     (sizeLo),
    .sizeHi     (sizeHi),
    .ctl        (ctl),
    .lane       (lane),
    .tsReq      (tsReq),
    .frameDone  (frameDone),
    .irqPulse   (irqPulse)
  );

  tsPackData #(
    .WORD_BYTES (WORD_BYTES),
    .BYTE_W     (BYTE_W),
    .BASE_W     (BASE_W),
    .EXT_W      (EXT_W),
    .LANE_W     (LANE_W)
  ) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .vidIn  (vidIn),
    .tsSnap (tsSnap),
    .ctl    (ctl),
    .lane   (lane),
    .wrData (wrData),
    .wrEn   (wrEn)
  );

endmodule

// File: rtl/tsPackerChk.sv
module tsPackerChk (
  input logic clk,
  input logic rstN,
  input logic vidValid,
  input logic fifoFull,
  input logic contMode,
  input logic flagClr,
  input logic frameDone,
  input logic irqPulse,
  input logic wrEn,
  input logic tsReq,
  input logic accept,
  input logic wordDone,
  input logic tsSlot
);

  // R10: nothing is taken while the FIFO is full
  a_r10_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !accept);

  // R8: single-shot capture halts while the flag is set
  a_r8_single_halt: assert property (@(posedge clk) disable iff (!rstN)
    (!contMode && frameDone) |-> !accept);

  // R12: the timestamp slot takes no byte
  a_r12_slot_block: assert property (@(posedge clk) disable iff (!rstN)
    tsSlot |-> !accept);

  // R3: a completed packet yields a data write then a timestamp write
  a_r3_ts_follows: assert property (@(posedge clk) disable iff (!rstN)
    tsSlot |-> (wrEn && $past(wordDone)));

  a_r3_slot_writes: assert property (@(posedge clk) disable iff (!rstN)
    tsSlot |=> wrEn);

  // R6: flag holds until cleared
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !flagClr) |=> frameDone);

  a_r6_flag_on_slot: assert property (@(posedge clk) disable iff (!rstN)
    tsSlot |-> frameDone);

  // R7: pulse lasts one cycle and comes with the flag
  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> frameDone);

  // R5: a capture request needs an offered, unblocked byte
  a_r5_req_valid: assert property (@(posedge clk) disable iff (!rstN)
    tsReq |-> (vidValid && !fifoFull && accept));

endmodule

bind tsPacker tsPackerChk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .vidValid  (vidValid),
  .fifoFull  (fifoFull),
  .contMode  (contMode),
  .flagClr   (flagClr),
  .frameDone (frameDone),
  .irqPulse  (irqPulse),
  .wrEn      (wrEn),
  .tsReq     (tsReq),
  .accept    (ctl.accept),
  .wordDone  (ctl.wordDone),
  .tsSlot    (ctl.tsSlot)
);

// File: tb/test_tsPacker.sv
`timescale 1ns/1ps
module test_tsPacker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  vidIn = '0;
  logic        vidValid = 1'b0;
  logic [11:0] sizeLo = 12'd1;
  logic [11:0] sizeHi = '0;
  logic        contMode = 1'b1;
  logic        irqMask = 1'b0;
  logic        flagClr = 1'b0;
  logic        fifoFull = 1'b0;
  logic        pktErrIn = 1'b0;
  logic        startErrIn = 1'b0;
  logic [41:0] tsSnap = '0;
  logic [63:0] wrData;
  logic        wrEn;
  logic        tsReq;
  logic        frameDone;
  logic        irqPulse;

  int          nChecks = 0;
  int          nFail = 0;
  int          irqCnt = 0;
  int          expIrq = 0;
  bit          finished = 1'b0;
  logic [31:0] cyc = '0;
  logic [63:0] expQ[$];
  logic [63:0] gotQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tsPacker i_tsPacker (
    .clk(clk), .rstN(rstN), .vidIn(vidIn), .vidValid(vidValid),
    .sizeLo(sizeLo), .sizeHi(sizeHi), .contMode(contMode), .irqMask(irqMask),
    .flagClr(flagClr), .fifoFull(fifoFull), .pktErrIn(pktErrIn),
    .startErrIn(startErrIn), .tsSnap(tsSnap), .wrData(wrData), .wrEn(wrEn),
    .tsReq(tsReq), .frameDone(frameDone), .irqPulse(irqPulse)
  );

  // Registered outputs are collected at the falling edge.
  initial forever begin
    @(negedge clk);
    if (rstN && wrEn) gotQ.push_back(wrData);
    if (rstN && irqPulse) irqCnt++;
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(int pid, int i);
    return 8'(pid * 37 + i * 13 + 5);
  endfunction

  task automatic drive(bit v, logic [7:0] b, bit full, bit pe, bit se);
    @(negedge clk);
    vidValid   = v;
    vidIn      = {b, cyc[1:0]};
    fifoFull   = full;
    pktErrIn   = pe;
    startErrIn = se;
    tsSnap     = {cyc[9:0], cyc * 32'h9E37_79B1};
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pulseClr();
    @(negedge clk);
    vidValid = 1'b0;
    flagClr  = 1'b1;
    @(negedge clk);
    flagClr  = 1'b0;
  endtask

  // Sends one packet and queues its expected words.
  task automatic sendPkt(int pid, int size, int gap, bit pe, bit se,
                         bit fullAt3, bit prePerr, bit slotByte);
    logic [63:0] w;
    logic [41:0] snap;
    logic [7:0]  b;
    w = '0;
    snap = '0;
    for (int i = 0; i < size; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) idle(1);
      if (fullAt3 && i == 3) begin
        drive(1'b1, 8'hEE, 1'b1, 1'b0, 1'b0);
        #1 check(tsReq == 1'b0, "R10 dropped byte raised tsReq", 64'(tsReq), 64'd0);
      end
      b = byteOf(pid, i);
      drive(1'b1, b, 1'b0, pe && (i == size / 2), se && (i == 0));
      #1;
      if (i == 0) begin
        snap = tsSnap;
        check(tsReq == 1'b1, "R5 tsReq on first byte", 64'(tsReq), 64'd1);
      end
      w[(i % 8) * 8 +: 8] = b;
      if ((i % 8) == 7 || i == size - 1) begin
        expQ.push_back(w);
        w = '0;
      end
    end
    expQ.push_back({pe | fullAt3 | prePerr, se, 20'd0, snap});
    if (!irqMask) expIrq++;
    if (slotByte) begin
      drive(1'b1, 8'h55, 1'b0, 1'b0, 1'b0);
      #1 check(tsReq == 1'b0, "R12 slot byte raised tsReq", 64'(tsReq), 64'd0);
    end else begin
      idle(1);
    end
  endtask

  task automatic compareQ(string req);
    idle(3);
    check(gotQ.size() == expQ.size(), {req, " word count"},
          64'(gotQ.size()), 64'(expQ.size()));
    while (expQ.size() > 0 && gotQ.size() > 0) begin
      logic [63:0] e;
      logic [63:0] g;
      e = expQ.pop_front();
      g = gotQ.pop_front();
      check(g === e, {req, " word"}, g, e);
    end
    expQ.delete();
    gotQ.delete();
  endtask

  initial begin
    int pid;
    pid = 0;
    // R13: reset state
    repeat (3) @(negedge clk);
    check(wrEn == 1'b0, "R13 wrEn in reset", 64'(wrEn), 64'd0);
    check(frameDone == 1'b0, "R13 frameDone in reset", 64'(frameDone), 64'd0);
    check(irqPulse == 1'b0, "R13 irqPulse in reset", 64'(irqPulse), 64'd0);
    rstN = 1'b1;
    idle(2);
    check(wrEn == 1'b0 && frameDone == 1'b0, "R13 idle after reset",
          64'({wrEn, frameDone}), 64'd0);

    // R1 R2 R3 R4 R9: length sweep, with and without gaps, continuous mode
    contMode = 1'b1;
    for (int gap = 0; gap <= 3; gap += 3) begin
      for (int size = 1; size <= 20; size++) begin
        sizeLo = 12'(size);
        sizeHi = '0;
        pid++;
        sendPkt(pid, size, gap, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        compareQ("R1 R2 R3 R4 R9 sweep");
        check(frameDone == 1'b1, "R6 R9 flag stays set", 64'(frameDone), 64'd1);
      end
    end
    check(irqCnt == expIrq, "R7 pulse per packet", 64'(irqCnt), 64'(expIrq));

    // R2: high length field, 4099 bytes
    sizeHi = 12'd1;
    sizeLo = 12'd3;
    pid++;
    sendPkt(pid, 4099, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compareQ("R2 high field length");
    sizeHi = '0;

    // R6: clearing the flag
    pulseClr();
    check(frameDone == 1'b0, "R6 flag cleared", 64'(frameDone), 64'd0);

    // R8: single-shot halt and resume
    contMode = 1'b0;
    sizeLo = 12'd6;
    pid++;
    sendPkt(pid, 6, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compareQ("R8 single first packet");
    check(frameDone == 1'b1, "R6 flag set after packet", 64'(frameDone), 64'd1);
    for (int i = 0; i < 9; i++) begin
      drive(1'b1, 8'hA0 + 8'(i), 1'b0, 1'b1, 1'b1);
      #1 check(tsReq == 1'b0, "R8 halted tsReq", 64'(tsReq), 64'd0);
    end
    idle(3);
    check(gotQ.size() == 0, "R8 halted writes", 64'(gotQ.size()), 64'd0);
    gotQ.delete();
    pulseClr();
    pid++;
    sendPkt(pid, 6, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compareQ("R8 resume after clear");
    contMode = 1'b1;

    // R11: error inputs ORed into the timestamp word
    sizeLo = 12'd11;
    pid++;
    sendPkt(pid, 11, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    compareQ("R11 R4 packet error");
    pid++;
    sendPkt(pid, 11, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    compareQ("R11 R4 start error");

    // R10: full drops a byte and marks the packet
    sizeLo = 12'd10;
    pid++;
    sendPkt(pid, 10, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    compareQ("R10 full drop");

    // R12: byte in the timestamp slot flags the next packet
    pid++;
    sendPkt(pid, 10, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    pid++;
    sendPkt(pid, 10, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    compareQ("R12 slot drop");

    // R7: masked completion gives no pulse
    irqMask = 1'b1;
    pid++;
    sendPkt(pid, 10, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compareQ("R7 masked packet");
    check(irqCnt == expIrq, "R7 masked pulse count", 64'(irqCnt), 64'(expIrq));
    irqMask = 1'b0;
    pid++;
    sendPkt(pid, 10, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    compareQ("R7 unmasked packet");
    check(irqCnt == expIrq, "R7 pulse count", 64'(irqCnt), 64'(expIrq));

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule